// File: doc/BRIEF.md
# Platform Interrupt Router

This block collects a set of interrupt sources and routes them to several targets. Each target is a context: one privilege level on one hardware thread. A source enters through its own gateway, which is built for edge or level signalling by a parameter bit. The gateway holds a pending flag until software takes the interrupt. Every source has a programmable priority. Every context has its own mask of enabled sources and its own priority threshold. A context's interrupt line rises when at least one pending source that the context enables has a priority strictly above the context's threshold.

Software uses one register port to program priorities, masks and thresholds, and to take and retire interrupts. A read of a context's claim register returns the ID of the best eligible source. The same read clears that source's pending flag, so the interrupt disappears from every other context at once. The source stays blocked until the same ID is written back to a claim register as a completion. Source IDs run from 1 to the number of sources, and ID 0 means "nothing to claim".

Top module: `irq_router`

## Requirements
- R1: After a synchronous active-low reset, all priorities, enable masks, thresholds and pending and claimed state are zero. Every interrupt output is low and every claim read returns 0.
- R2: The address is {region[1:0], index[7:0]}, with region 0 = priority, 1 = enable mask, 2 = threshold, 3 = claim/complete. A priority lives at region 0 with index equal to the source ID and holds only the low PRIO_W bits of the written data. Index 0 reads 0 and ignores writes.
- R3: Region 1, index c, holds context c's enable mask in data bits [NUM_SRC:1], where bit k enables source k. Data bit 0 reads 0. A source that is not enabled for a context neither raises that context's line nor is returned by that context's claim.
- R4: A source with priority 0 is never delivered. Its pending flag is kept, and it is delivered once it is given a nonzero priority.
- R5: Region 2, index c, holds context c's threshold. The context's line is high, and its claim returns a nonzero ID, only when the best eligible priority is strictly greater than that threshold.
- R6: Among eligible sources, the one with the highest priority wins. When priorities tie, the lowest ID wins.
- R7: A read of region 3, index c, returns the winning ID for context c and clears that source's pending flag at the same clock edge. Other contexts stop seeing the source from the next cycle on.
- R8: A claimed source does not become pending again, and is not returned by any claim, until a completion carrying its ID arrives.
- R9: An edge source latches one rising edge into pending. Further edges while it is pending merge into that one. Edges while it is claimed are dropped.
- R10: A level source becomes pending whenever its input is high and it is not claimed. After completion, an input that is still high makes it pending again one cycle later.
- R11: A completion write of an ID that is not currently claimed has no effect.
- R12: A claim read when nothing is eligible returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Source inputs; bit k-1 is source ID k |
| reg_valid_i | input | 1 | Register access strobe, one access per cycle |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | {region, index} register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid in the cycle of the read |
| irq_o | output | NUM_CTX | Interrupt line per context |

## Verification
A pending or claimed flag that holds the wrong value shows up at the ports within one cycle. Either the interrupt line of an enabling context is wrong, or the next claim read returns the wrong ID. A source that was lost, or claimed twice, is caught by reading the claim register back to back. A claimed flag that fails to clear only becomes visible after the completion: a level source that is still high should be claimable again one cycle later. The bench therefore checks each completion by waiting one cycle and then reading the claim register.

// File: rtl/irq_pkg.sv
// Shared definitions for the interrupt router.
// Assumes a two-bit region field at the top of the register address.
package irq_pkg;

    typedef enum logic [1:0] {
        REG_PRIO   = 2'd0,
        REG_ENABLE = 2'd1,
        REG_THRESH = 2'd2,
        REG_CLAIM  = 2'd3
    } reg_region_e;

endpackage

// File: rtl/irq_gateway.sv
// Per-source gateway: turns a raw input into a pending flag and tracks
// whether the source is claimed. LEVEL picks level (1) or edge (0) capture.
// Assumes claim and complete never arrive in the same cycle (single port).
module irq_gateway #(
    parameter bit LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pend_o,
    output logic busy_o
);

    logic prev_q;
    logic set_req;

    // Decide whether this cycle's input opens a new request.
    always_comb begin
        if (LEVEL) begin
            set_req = src_i && !busy_o;
        end else begin
            set_req = src_i && !prev_q && !busy_o;
        end
    end

    // Remember the previous input level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_i;
    end

    // Pending flag: a claim clears it, a new request sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_o <= 1'b0;
        else if (claim_i) pend_o <= 1'b0;
        else if (set_req) pend_o <= 1'b1;
    end

    // Claimed flag: set on claim, cleared by a matching completion.
    always_ff @(posedge clk) begin
        if (!rst_n)          busy_o <= 1'b0;
        else if (claim_i)    busy_o <= 1'b1;
        else if (complete_i) busy_o <= 1'b0;
    end

endmodule

// File: rtl/irq_arbiter.sv
// Per-context arbiter: finds the highest-priority pending, enabled source
// (lowest ID on ties), then gates it with the context threshold.
// Assumes priority 0 means "never deliver".
module irq_arbiter #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 4
) (
    input  logic [NUM_SRC-1:0]             pend_i,
    input  logic [NUM_SRC-1:0]             en_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]              thr_i,
    output logic [ID_W-1:0]                claim_id_o,
    output logic                           irq_o
);

    logic [ID_W-1:0]   best_id;
    logic [PRIO_W-1:0] best_prio;

    // Scan in ascending ID order; strict compare keeps the lowest ID on ties
    // and never lets priority 0 win.
    always_comb begin
        best_id   = '0;
        best_prio = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (pend_i[k] && en_i[k] && (prio_i[k] > best_prio)) begin
                best_id   = ID_W'(k + 1);
                best_prio = prio_i[k];
            end
        end
    end

    // Deliver only when the winner beats the threshold strictly.
    always_comb begin
        irq_o      = (best_prio > thr_i);
        claim_id_o = irq_o ? best_id : '0;
    end

endmodule

// File: rtl/irq_cfg.sv
// Configuration storage: source priorities, per-context enable masks and
// per-context thresholds, written through the decoded register port.
// Assumes the caller has qualified wr_i with valid and write.
module irq_cfg
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3,
    parameter int IDX_W   = 8,
    parameter int DATA_W  = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_i,
    input  reg_region_e                         region_i,
    input  logic [IDX_W-1:0]                    idx_i,
    input  logic [DATA_W-1:0]                   wdata_i,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]      prio_o,
    output logic [NUM_CTX-1:0][NUM_SRC-1:0]     en_o,
    output logic [NUM_CTX-1:0][PRIO_W-1:0]      thr_o
);

    genvar k, c;

    generate
        for (k = 0; k < NUM_SRC; k++) begin : g_prio
            // Priority register of source ID k+1.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    prio_o[k] <= '0;
                else if (wr_i && region_i == REG_PRIO && idx_i == IDX_W'(k + 1))
                    prio_o[k] <= wdata_i[PRIO_W-1:0];
            end
        end

        for (c = 0; c < NUM_CTX; c++) begin : g_ctx
            // Enable mask of context c; data bit 0 has no source.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    en_o[c] <= '0;
                else if (wr_i && region_i == REG_ENABLE && idx_i == IDX_W'(c))
                    en_o[c] <= wdata_i[NUM_SRC:1];
            end

            // Threshold of context c.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    thr_o[c] <= '0;
                else if (wr_i && region_i == REG_THRESH && idx_i == IDX_W'(c))
                    thr_o[c] <= wdata_i[PRIO_W-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/irq_router.sv
// Platform interrupt router top: gateways, configuration, one arbiter per
// context, claim/complete handling and the register read mux.
// Assumes one register access per cycle; read data is combinational.
module irq_router
    import irq_pkg::*;
#(
    parameter int               NUM_SRC   = 8,
    parameter int               NUM_CTX   = 2,
    parameter int               PRIO_W    = 3,
    parameter int               ADDR_W    = 10,
    parameter int               DATA_W    = 32,
    parameter logic [NUM_SRC-1:0] SRC_LEVEL = 8'hF0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               reg_valid_i,
    input  logic               reg_write_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic [NUM_CTX-1:0] irq_o
);

    localparam int ID_W  = $clog2(NUM_SRC + 1);
    localparam int IDX_W = ADDR_W - 2;

    reg_region_e                         region;
    logic [IDX_W-1:0]                    idx;
    logic                                cfg_wr;
    logic                                claim_rd;
    logic                                complete_wr;
    logic [NUM_SRC-1:0]                  pend;
    logic [NUM_SRC-1:0]                  busy;
    logic [NUM_SRC-1:0]                  claim_src;
    logic [NUM_SRC-1:0]                  complete_src;
    logic [NUM_SRC-1:0][PRIO_W-1:0]      prio;
    logic [NUM_CTX-1:0][NUM_SRC-1:0]     en;
    logic [NUM_CTX-1:0][PRIO_W-1:0]      thr;
    logic [NUM_CTX-1:0][ID_W-1:0]        claim_id;

    // Split the address and qualify the access kinds.
    always_comb begin
        region      = reg_region_e'(reg_addr_i[ADDR_W-1 -: 2]);
        idx         = reg_addr_i[IDX_W-1:0];
        cfg_wr      = reg_valid_i && reg_write_i;
        claim_rd    = reg_valid_i && !reg_write_i && region == REG_CLAIM
                      && idx < IDX_W'(NUM_CTX);
        complete_wr = reg_valid_i && reg_write_i && region == REG_CLAIM
                      && idx < IDX_W'(NUM_CTX);
    end

    irq_cfg #(
        .NUM_SRC (NUM_SRC),
        .NUM_CTX (NUM_CTX),
        .PRIO_W  (PRIO_W),
        .IDX_W   (IDX_W),
        .DATA_W  (DATA_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (cfg_wr),
        .region_i (region),
        .idx_i    (idx),
        .wdata_i  (reg_wdata_i),
        .prio_o   (prio),
        .en_o     (en),
        .thr_o    (thr)
    );

    genvar k, c;

    generate
        for (c = 0; c < NUM_CTX; c++) begin : g_arb
            irq_arbiter #(
                .NUM_SRC (NUM_SRC),
                .PRIO_W  (PRIO_W),
                .ID_W    (ID_W)
            ) u_arb (
                .pend_i     (pend),
                .en_i       (en[c]),
                .prio_i     (prio),
                .thr_i      (thr[c]),
                .claim_id_o (claim_id[c]),
                .irq_o      (irq_o[c])
            );
        end

        for (k = 0; k < NUM_SRC; k++) begin : g_gw
            // Route the claim and completion of source ID k+1 to its gateway.
            always_comb begin
                claim_src[k] = 1'b0;
                for (int j = 0; j < NUM_CTX; j++) begin
                    if (claim_rd && idx == IDX_W'(j) && claim_id[j] == ID_W'(k + 1))
                        claim_src[k] = 1'b1;
                end
                complete_src[k] = complete_wr && reg_wdata_i == DATA_W'(k + 1);
            end

            irq_gateway #(
                .LEVEL (SRC_LEVEL[k])
            ) u_gw (
                .clk        (clk),
                .rst_n      (rst_n),
                .src_i      (src_i[k]),
                .claim_i    (claim_src[k]),
                .complete_i (complete_src[k]),
                .pend_o     (pend[k]),
                .busy_o     (busy[k])
            );
        end
    endgenerate

    // Read mux over the four register regions.
    always_comb begin
        reg_rdata_o = '0;
        case (region)
            REG_PRIO: begin
                for (int j = 0; j < NUM_SRC; j++)
                    if (idx == IDX_W'(j + 1)) reg_rdata_o[PRIO_W-1:0] = prio[j];
            end
            REG_ENABLE: begin
                for (int j = 0; j < NUM_CTX; j++)
                    if (idx == IDX_W'(j)) reg_rdata_o[NUM_SRC:1] = en[j];
            end
            REG_THRESH: begin
                for (int j = 0; j < NUM_CTX; j++)
                    if (idx == IDX_W'(j)) reg_rdata_o[PRIO_W-1:0] = thr[j];
            end
            default: begin
                for (int j = 0; j < NUM_CTX; j++)
                    if (idx == IDX_W'(j)) reg_rdata_o[ID_W-1:0] = claim_id[j];
            end
        endcase
    end

endmodule

// File: rtl/irq_router_chk.sv
// Property checker for the interrupt router, bound to every instance.
// Assumes the bound signals are the gateway pending/claimed vectors.
module irq_router_chk #(
    parameter int NUM_SRC = 8,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            reg_valid_i,
    input logic                            reg_write_i,
    input logic [ADDR_W-1:0]               reg_addr_i,
    input logic [DATA_W-1:0]               reg_wdata_i,
    input logic [DATA_W-1:0]               reg_rdata_o,
    input logic [NUM_CTX-1:0]              irq_o,
    input logic [NUM_SRC-1:0]              pend,
    input logic [NUM_SRC-1:0]              busy,
    input logic [NUM_CTX-1:0][PRIO_W-1:0]  thr
);

    localparam int ID_W = $clog2(NUM_SRC + 1);
    localparam int PAD  = 2 ** ID_W;

    logic            is_claim;
    logic            is_complete;
    logic [PAD-1:0]  pend_pad;
    logic [PAD-1:0]  busy_pad;
    logic            claimed_q;
    logic [ID_W-1:0] last_id_q;

    // Classify the access and pad the flag vectors so IDs index directly.
    always_comb begin
        is_claim    = reg_valid_i && !reg_write_i && reg_addr_i[ADDR_W-1 -: 2] == 2'd3;
        is_complete = reg_valid_i && reg_write_i && reg_addr_i[ADDR_W-1 -: 2] == 2'd3;
        pend_pad    = PAD'({pend, 1'b0});
        busy_pad    = PAD'({busy, 1'b0});
    end

    // Remember the last successful claim for a check one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            claimed_q <= 1'b0;
            last_id_q <= '0;
        end else begin
            claimed_q <= is_claim && reg_rdata_o != '0;
            last_id_q <= reg_rdata_o[ID_W-1:0];
        end
    end

    // R7
    claim_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claimed_q |-> (!pend_pad[last_id_q] && busy_pad[last_id_q]));

    // R7
    claim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_claim |-> (reg_rdata_o <= DATA_W'(NUM_SRC)));

    // R8
    pend_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & busy) == '0);

    // R11
    stray_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_complete && reg_wdata_i <= DATA_W'(NUM_SRC)
         && !busy_pad[reg_wdata_i[ID_W-1:0]]) |=> $stable(busy));

    // R12
    empty_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_claim && reg_rdata_o == '0) |=> $stable(busy));

    genvar c;
    generate
        for (c = 0; c < NUM_CTX; c++) begin : g_thr
            // R5
            max_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (thr[c] == {PRIO_W{1'b1}}) |-> !irq_o[c]);
        end
    endgenerate

endmodule

bind irq_router irq_router_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX),
    .PRIO_W  (PRIO_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_valid_i (reg_valid_i),
    .reg_write_i (reg_write_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .pend        (pend),
    .busy        (busy),
    .thr         (thr)
);

// File: tb/irq_router_tb.sv
// Self-checking bench: a register vector table, then directed gateway,
// arbitration, threshold and claim/complete tests.
module irq_router_tb;

    localparam int NUM_SRC = 8;
    localparam int NUM_CTX = 2;
    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 32;
    localparam int NV      = 19;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] src = '0;
    logic               valid = 1'b0;
    logic               wr = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic [DATA_W-1:0]  wdata = '0;
    logic [DATA_W-1:0]  rdata;
    logic [NUM_CTX-1:0] irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    irq_router #(
        .NUM_SRC   (NUM_SRC),
        .NUM_CTX   (NUM_CTX),
        .PRIO_W    (3),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SRC_LEVEL (8'hF0)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .reg_valid_i (valid),
        .reg_write_i (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    // 125 MHz clock
    always #4 clk = ~clk;

    // Vector: {req[3:0], read, region[1:0], index[7:0], data[31:0]}
    function automatic logic [46:0] mk(int req, bit rd, int rg, int ix, int d);
        return {4'(req), rd, 2'(rg), 8'(ix), 32'(d)};
    endfunction

    localparam logic [46:0] VEC [NV] = '{
        mk(1, 1, 0, 3, 0),        // R1 priority reads 0
        mk(1, 1, 1, 0, 0),        // R1 enable mask reads 0
        mk(1, 1, 3, 0, 0),        // R1 claim reads 0
        mk(2, 0, 0, 1, 2),        // R2 writes
        mk(2, 0, 0, 2, 5),
        mk(2, 0, 0, 3, 5),
        mk(2, 1, 0, 2, 5),
        mk(2, 0, 0, 1, 'hF),      // R2 truncation to 3 bits
        mk(2, 1, 0, 1, 7),
        mk(2, 0, 0, 1, 2),
        mk(2, 1, 0, 1, 2),
        mk(2, 0, 0, 0, 5),        // R2 index 0 ignored
        mk(2, 1, 0, 0, 0),
        mk(3, 0, 1, 0, 'h1F),     // R3 ctx0 enables 1..4, bit 0 dropped
        mk(3, 1, 1, 0, 'h1E),
        mk(3, 0, 1, 1, 'h02),     // R3 ctx1 enables source 1 only
        mk(5, 0, 2, 1, 1),        // R5 ctx1 threshold 1
        mk(5, 1, 2, 1, 1),
        mk(12, 1, 3, 1, 0)        // R12 empty claim
    };

    task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_op(bit w, int rg, int ix, int d, output logic [DATA_W-1:0] rd);
        @(negedge clk);
        valid = 1'b1;
        wr    = w;
        addr  = {2'(rg), 8'(ix)};
        wdata = DATA_W'(d);
        #1 rd = rdata;
        @(posedge clk);
        #1 valid = 1'b0;
    endtask

    task automatic wr_reg(int rg, int ix, int d);
        logic [DATA_W-1:0] dummy;
        reg_op(1'b1, rg, ix, d, dummy);
    endtask

    task automatic claim(int ctx, int exp, string req);
        logic [DATA_W-1:0] r;
        reg_op(1'b0, 3, ctx, 0, r);
        chk(req, r, DATA_W'(exp));
    endtask

    task automatic pulse(int id);
        @(negedge clk);
        src[id-1] = 1'b1;
        @(negedge clk);
        src[id-1] = 1'b0;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] r;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 irq after reset", DATA_W'(irq), 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            reg_op(!VEC[i][42], int'(VEC[i][41:40]), int'(VEC[i][39:32]),
                   int'(VEC[i][31:0]), r);
            if (VEC[i][42])
                chk($sformatf("R%0d table[%0d]", VEC[i][46:43], i), r, VEC[i][31:0]);
        end

        // R6/R7/R3: arbitration and atomic claim
        pulse(1); pulse(2); pulse(3);
        chk("R9 both lines up", DATA_W'(irq), 3);
        claim(0, 2, "R6 tie lowest ID");
        claim(0, 3, "R6 next of tie");
        chk("R3 ctx1 still sees src1", DATA_W'(irq[1]), 1);
        claim(0, 1, "R6 lower priority last");
        chk("R7 ctx1 line drops", DATA_W'(irq[1]), 0);
        claim(1, 0, "R7 hidden from ctx1");

        // R8/R9: edge while claimed is dropped
        pulse(2);
        claim(0, 0, "R8 no re-pend while claimed");
        wr_reg(3, 0, 2);
        idle();
        claim(0, 0, "R9 edge during claim dropped");
        pulse(2);
        claim(0, 2, "R9 new edge after complete");
        wr_reg(3, 0, 2); wr_reg(3, 0, 3); wr_reg(3, 0, 1);

        // R9: repeated edges merge
        pulse(3); pulse(3);
        claim(0, 3, "R9 merged edge");
        claim(0, 0, "R9 only one claim");
        wr_reg(3, 0, 3);

        // R5: strict threshold
        wr_reg(2, 0, 5);
        pulse(2);
        chk("R5 equal to threshold blocked", DATA_W'(irq[0]), 0);
        claim(0, 0, "R5 claim blocked");
        wr_reg(2, 0, 4);
        chk("R5 above threshold", DATA_W'(irq[0]), 1);
        claim(0, 2, "R5 claim after lowering");
        wr_reg(3, 0, 2);
        wr_reg(2, 0, 0);

        // R4: priority 0 held back
        pulse(4);
        chk("R4 prio0 no line", DATA_W'(irq[0]), 0);
        claim(0, 0, "R4 prio0 no claim");
        wr_reg(0, 4, 1);
        chk("R4 delivered after prio", DATA_W'(irq[0]), 1);
        claim(0, 4, "R4 claim after prio");
        wr_reg(3, 0, 4);

        // R3: mask
        pulse(3);
        chk("R3 ctx1 masked line", DATA_W'(irq[1]), 0);
        claim(1, 0, "R3 ctx1 masked claim");
        chk("R3 ctx0 line", DATA_W'(irq[0]), 1);
        claim(0, 3, "R3 ctx0 claim");
        wr_reg(3, 0, 3);

        // R10/R11: level source 5
        wr_reg(0, 5, 3);
        wr_reg(1, 0, 'h3E);
        @(negedge clk); src[4] = 1'b1;
        claim(0, 5, "R10 level pends");
        claim(0, 0, "R8 level blocked while claimed");
        wr_reg(3, 0, 7);
        idle();
        claim(0, 0, "R11 stray complete ignored");
        wr_reg(3, 0, 5);
        idle();
        claim(0, 5, "R10 re-pend while high");
        @(negedge clk); src[4] = 1'b0;
        wr_reg(3, 0, 5);
        idle();
        claim(0, 0, "R10 low input no pend");
        chk("R10 line low", DATA_W'(irq[0]), 0);

        // R1: mid-run reset
        pulse(2);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1 chk("R1 irq after reset", DATA_W'(irq), 0);
        reg_op(1'b0, 0, 2, 0, r);
        chk("R1 priority cleared", r, 0);
        reg_op(1'b0, 1, 0, 0, r);
        chk("R1 mask cleared", r, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule